// File: doc/BRIEF.md
# TDM Timeslot Payload Mapper

This block places a byte stream of cell payload onto a serial time-division backplane frame of 32 eight-bit timeslots, and pulls payload bytes back out of the receive line in the same slots. A mode input selects which timeslots carry payload: T1 grouped, T1 spaced, T1 with a reserved signalling slot, or E1 with its framing and signalling slots excluded. On transmit, slots that carry no payload are left undriven (output enable low). On receive, those slots are discarded.

The block runs from a bit clock at twice the line data rate, so every bit cell spans two clock cycles. Transmit data changes at the start of a cell. Receive data is sampled at the cell midpoint. An active-low frame sync realigns the frame. Payload bytes come from an upstream source through a ready/take handshake. When no byte is ready as a payload slot begins, an all-ones idle byte is sent and an underrun strobe is raised.

Top module: `tdm_slot_mapper`

## Requirements
- R1: When `sync_n` is sampled low at a clock edge, the cycle after that edge is the first cycle of timeslot 0, bit 7. Each bit cell lasts two cycles and each frame lasts 32 x 8 cells, after which timeslot 0 follows timeslot 31.
- R2: With `mode_sel` = 0 (T1 grouped), timeslots 0 to 23 carry payload and timeslots 24 to 31 are unused.
- R3: With `mode_sel` = 1 (T1 spaced), timeslots whose number is a multiple of four are unused and the other 24 carry payload.
- R4: With `mode_sel` = 2 (T1 with signalling), timeslots 0 to 22 carry payload and timeslots 23 to 31 are unused.
- R5: With `mode_sel` = 3 (E1), timeslots 0 and 16 are unused and the other 30 carry payload.
- R6: In a payload timeslot, `tx_oe` is high for all 16 cycles of the slot and `tx_line` sends the byte most significant bit first, each bit held for both cycles of its cell. In an unused slot, `tx_oe` and `tx_line` are low.
- R7: `rx_line` is sampled at the clock edge that ends the first cycle of each cell, and the first sample of a slot is bit 7. After bit 0 of a payload slot is sampled, `rx_valid` is high for one cycle with the assembled byte on `rx_data`. Unused slots never raise `rx_valid`.
- R8: If `pay_ready` is low at the edge where a payload slot begins, the slot sends 0xFF and `underrun` is high for the first cycle of that slot. No byte is consumed.
- R9: `pay_take` is high, and the byte on `pay_data` is captured, only in the cycle that ends at the edge where a payload slot begins while `pay_ready` is high.
- R10: A new `mode_sel` value takes effect only at a frame boundary, either a sync or the wrap from timeslot 31 to timeslot 0.
- R11: After reset the mode is T1 grouped, and `tx_oe`, `rx_valid` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame sync, one cycle |
| mode_sel | input | 2 | Slot map select: 0 grouped, 1 spaced, 2 signalling, 3 E1 |
| pay_data | input | 8 | Next payload byte to transmit |
| pay_ready | input | 1 | A payload byte is available |
| pay_take | output | 1 | Payload byte consumed at this edge |
| rx_line | input | 1 | Serial receive data |
| tx_line | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable, low in unused slots |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| underrun | output | 1 | Idle byte sent because no payload was ready |

## Verification
On every cycle the assertions check the slot exclusions of each mode against the live frame position, that a sync realigns the counters and that cells last two cycles, that the mode changes only at the start of timeslot 0, that an underrun always coincides with a driven idle bit, and that receive strobes occur only in enabled slots as single pulses. The bench's scenarios show what no single-cycle property can: the exact bit order and byte values on both lines across whole frames, the per-frame count of enabled cycles and received bytes in each mode, a mode request deferred across the rest of a frame, a mid-frame resync, and a run of underruns with the source stalled.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;

    typedef enum logic [1:0] {
        MAP_T1_GROUPED = 2'd0,
        MAP_T1_SPACED  = 2'd1,
        MAP_T1_SIG     = 2'd2,
        MAP_E1         = 2'd3
    } map_mode_e;

    // Does timeslot 'slot' carry payload under map 'mode'?
    function automatic logic slot_carries_payload(map_mode_e mode, int slot);
        logic used;
        case (mode)
            MAP_T1_GROUPED: used = (slot < 24);
            MAP_T1_SPACED:  used = ((slot % 4) != 0);
            MAP_T1_SIG:     used = (slot < 23);
            default:        used = (slot != 0) && (slot != 16);
        endcase
        return used;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int SLOTS = 32,
    parameter int BITS  = 8,
    localparam int SW   = $clog2(SLOTS),
    localparam int BW   = $clog2(BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_n,
    output logic [SW-1:0] slot_o,
    output logic [SW-1:0] next_slot_o,
    output logic [BW-1:0] bit_o,
    output logic          phase_o,
    output logic          load_o,
    output logic          frame_o,
    output logic          shift_o,
    output logic          sample_o,
    output logic          last_bit_o
);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic [BW-1:0] bit_idx;
        logic          phase;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d    = tm_q;
        load_o  = 1'b0;
        frame_o = 1'b0;
        shift_o = 1'b0;
        if (!sync_n) begin
            tm_d.slot    = '0;
            tm_d.bit_idx = BW'(BITS - 1);
            tm_d.phase   = 1'b0;
            load_o       = 1'b1;
            frame_o      = 1'b1;
        end else if (!tm_q.phase) begin
            tm_d.phase = 1'b1;
        end else begin
            tm_d.phase = 1'b0;
            if (tm_q.bit_idx == '0) begin
                tm_d.bit_idx = BW'(BITS - 1);
                load_o       = 1'b1;
                if (tm_q.slot == SW'(SLOTS - 1)) begin
                    tm_d.slot = '0;
                    frame_o   = 1'b1;
                end else begin
                    tm_d.slot = tm_q.slot + SW'(1);
                end
            end else begin
                tm_d.bit_idx = tm_q.bit_idx - BW'(1);
                shift_o      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q.slot    <= '0;
            tm_q.bit_idx <= BW'(BITS - 1);
            tm_q.phase   <= 1'b0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign slot_o      = tm_q.slot;
    assign next_slot_o = tm_d.slot;
    assign bit_o       = tm_q.bit_idx;
    assign phase_o     = tm_q.phase;
    assign sample_o    = !tm_q.phase;
    assign last_bit_o  = (tm_q.bit_idx == '0);

    assert_sync_realigns_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |=> (slot_o == '0) && (bit_o == BW'(BITS - 1)) && !phase_o);

    assert_cell_two_cycles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n && !phase_o) |=> (phase_o && $stable(bit_o) && $stable(slot_o)));

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
    parameter int          W         = 8,
    parameter logic [W-1:0] IDLE_BYTE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic         live_next_i,
    input  logic         pay_ready_i,
    input  logic [W-1:0] pay_data_i,
    output logic         pay_take_o,
    output logic         tx_line_o,
    output logic         tx_oe_o,
    output logic         underrun_o,
    output logic         live_o
);

    typedef struct packed {
        logic [W-1:0] sr;
        logic         live;
        logic         under;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d       = tx_q;
        tx_d.under = 1'b0;
        pay_take_o = load_i && live_next_i && pay_ready_i;
        if (load_i) begin
            tx_d.live  = live_next_i;
            tx_d.sr    = pay_take_o ? pay_data_i : IDLE_BYTE;
            tx_d.under = live_next_i && !pay_ready_i;
        end else if (shift_i) begin
            tx_d.sr = {tx_q.sr[W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q.sr    <= IDLE_BYTE;
            tx_q.live  <= 1'b0;
            tx_q.under <= 1'b0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_oe_o    = tx_q.live;
    assign tx_line_o  = tx_q.live && tx_q.sr[W-1];
    assign underrun_o = tx_q.under;
    assign live_o     = tx_q.live;

    assert_idle_on_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> (tx_oe_o && tx_line_o));

    assert_take_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pay_take_o |-> pay_ready_i);

endmodule

// File: rtl/tdm_rx_deserializer.sv
module tdm_rx_deserializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_i,
    input  logic         last_bit_i,
    input  logic         live_i,
    input  logic         rx_line_i,
    output logic [W-1:0] rx_data_o,
    output logic         rx_valid_o
);

    typedef struct packed {
        logic [W-1:0] sr;
        logic [W-1:0] data;
        logic         valid;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        if (sample_i) begin
            rx_d.sr = {rx_q.sr[W-2:0], rx_line_i};
            if (last_bit_i && live_i) begin
                rx_d.data  = {rx_q.sr[W-2:0], rx_line_i};
                rx_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_data_o  = rx_q.data;
    assign rx_valid_o = rx_q.valid;

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper #(
    parameter int          SLOTS     = 32,
    parameter int          BITS      = 8,
    parameter logic [7:0]  IDLE_BYTE = 8'hFF,
    localparam int         SW        = $clog2(SLOTS),
    localparam int         BW        = $clog2(BITS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_n,
    input  logic [1:0] mode_sel,
    input  logic [7:0] pay_data,
    input  logic       pay_ready,
    output logic       pay_take,
    input  logic       rx_line,
    output logic       tx_line,
    output logic       tx_oe,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       underrun
);
    import tdm_map_pkg::*;

    typedef struct packed {
        map_mode_e mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SW-1:0] slot, next_slot;
    logic [BW-1:0] bit_idx;
    logic          phase, load, frame, shift, sample, last_bit;
    logic          live_next, live;

    tdm_frame_timer #(.SLOTS(SLOTS), .BITS(BITS)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_n     (sync_n),
        .slot_o     (slot),
        .next_slot_o(next_slot),
        .bit_o      (bit_idx),
        .phase_o    (phase),
        .load_o     (load),
        .frame_o    (frame),
        .shift_o    (shift),
        .sample_o   (sample),
        .last_bit_o (last_bit)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (frame) ctl_d.mode = map_mode_e'(mode_sel);
        live_next = slot_carries_payload(ctl_d.mode, int'(next_slot));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.mode <= MAP_T1_GROUPED;
        else        ctl_q      <= ctl_d;
    end

    tdm_tx_serializer #(.W(BITS), .IDLE_BYTE(IDLE_BYTE)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .shift_i    (shift),
        .live_next_i(live_next),
        .pay_ready_i(pay_ready),
        .pay_data_i (pay_data),
        .pay_take_o (pay_take),
        .tx_line_o  (tx_line),
        .tx_oe_o    (tx_oe),
        .underrun_o (underrun),
        .live_o     (live)
    );

    tdm_rx_deserializer #(.W(BITS)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample),
        .last_bit_i(last_bit),
        .live_i    (live),
        .rx_line_i (rx_line),
        .rx_data_o (rx_data),
        .rx_valid_o(rx_valid)
    );

    assert_grouped_tail_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MAP_T1_GROUPED && slot >= SW'(24)) |-> !tx_oe);

    assert_spaced_gap_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MAP_T1_SPACED && slot[1:0] == 2'b00) |-> !tx_oe);

    assert_sig_slot_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MAP_T1_SIG && slot >= SW'(23)) |-> !tx_oe);

    assert_e1_frame_slots_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MAP_E1 && (slot == SW'(0) || slot == SW'(16))) |-> !tx_oe);

    assert_rx_in_live_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> tx_oe);

    assert_mode_at_frame_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.mode) |-> (slot == '0 && bit_idx == BW'(BITS - 1) && !phase));

endmodule

// File: tb/tdm_slot_mapper_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_mapper_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic [1:0] mode_sel = 2'd0;
    logic [7:0] pay_data;
    logic       pay_ready;
    logic       pay_take;
    logic       rx_line = 1'b0;
    logic       tx_line, tx_oe, rx_valid, underrun;
    logic [7:0] rx_data;

    always #2 clk = ~clk;

    // stimulus requests, applied one ns after each rising edge
    logic       sync_req = 1'b0;
    logic [1:0] mode_req = 2'd0;
    logic       src_en   = 1'b1;
    logic [7:0] src_byte = 8'h10;
    logic [7:0] lfsr     = 8'hA5;

    assign pay_data  = src_byte;
    assign pay_ready = src_en;

    tdm_slot_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mode_sel(mode_sel),
        .pay_data(pay_data), .pay_ready(pay_ready), .pay_take(pay_take),
        .rx_line(rx_line), .tx_line(tx_line), .tx_oe(tx_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .underrun(underrun)
    );

    int vectors = 0;
    int miscompares = 0;
    int oe_cycles = 0;
    int rx_bytes = 0;
    int under_cnt = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit bench_slot_used(int mode, int s);
        if (mode == 0) return s <= 23;
        if (mode == 1) return (s % 4) != 0;
        if (mode == 2) return s <= 22;
        return !(s == 0 || s == 16);
    endfunction

    function automatic string map_tag(int mode);
        case (mode)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // reference model state
    int m_phase = 0, m_bit = 7, m_slot = 0, m_mode = 0;
    bit m_live = 0, m_under = 0, m_rxvalid = 0;
    logic [7:0] m_sr = 8'hFF, m_rxsr = 8'h00, m_rxdata = 8'h00;
    int n_phase, n_bit, n_slot, n_mode;
    bit n_live, n_under, n_rxvalid, exp_take;
    logic [7:0] n_sr, n_rxsr, n_rxdata;

    task automatic model_next();
        bit ld, fr, sh, nl;
        ld = 0; fr = 0; sh = 0;
        n_phase = m_phase; n_bit = m_bit; n_slot = m_slot;
        if (!sync_n) begin
            n_phase = 0; n_bit = 7; n_slot = 0; ld = 1; fr = 1;
        end else if (m_phase == 0) begin
            n_phase = 1;
        end else begin
            n_phase = 0;
            if (m_bit == 0) begin
                n_bit = 7; ld = 1;
                n_slot = (m_slot + 1) % 32;
                fr = (m_slot == 31);
            end else begin
                n_bit = m_bit - 1; sh = 1;
            end
        end
        n_mode = fr ? int'(mode_sel) : m_mode;
        nl = bench_slot_used(n_mode, n_slot);
        exp_take = ld && nl && pay_ready;
        n_live = m_live; n_under = 0; n_sr = m_sr;
        if (ld) begin
            n_live  = nl;
            n_sr    = exp_take ? pay_data : 8'hFF;
            n_under = nl && !pay_ready;
        end else if (sh) begin
            n_sr = {m_sr[6:0], 1'b1};
        end
        n_rxvalid = 0; n_rxsr = m_rxsr; n_rxdata = m_rxdata;
        if (m_phase == 0) begin
            n_rxsr = {m_rxsr[6:0], rx_line};
            if (m_bit == 0 && m_live) begin
                n_rxdata  = {m_rxsr[6:0], rx_line};
                n_rxvalid = 1;
            end
        end
    endtask

    // compare at every falling edge
    always @(negedge clk) begin
        model_next();
        if (rst_n) begin
            chk({map_tag(m_mode), " tx_oe"}, {7'd0, tx_oe}, {7'd0, m_live});
            chk("R6 tx_line", {7'd0, tx_line}, {7'd0, m_live & m_sr[7]});
            chk("R8 underrun", {7'd0, underrun}, {7'd0, m_under});
            chk("R9 pay_take", {7'd0, pay_take}, {7'd0, exp_take});
            chk("R7 rx_valid", {7'd0, rx_valid}, {7'd0, m_rxvalid});
            if (m_rxvalid) chk("R7 rx_data", rx_data, m_rxdata);
            if (tx_oe) oe_cycles++;
            if (rx_valid) rx_bytes++;
            if (underrun) under_cnt++;
        end
    end

    // commit model, then drive new inputs
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            m_phase = 0; m_bit = 7; m_slot = 0; m_mode = 0;
            m_live = 0; m_under = 0; m_sr = 8'hFF;
            m_rxsr = 8'h00; m_rxdata = 8'h00; m_rxvalid = 0;
        end else begin
            m_phase = n_phase; m_bit = n_bit; m_slot = n_slot; m_mode = n_mode;
            m_live = n_live; m_under = n_under; m_sr = n_sr;
            m_rxsr = n_rxsr; m_rxdata = n_rxdata; m_rxvalid = n_rxvalid;
            if (exp_take) src_byte = src_byte + 8'd7;
        end
        sync_n   = !sync_req;
        sync_req = 1'b0;
        mode_sel = mode_req;
        if (m_phase == 0) begin
            rx_line = lfsr[0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
    end

    task automatic do_sync(logic [1:0] mode);
        mode_req = mode;
        sync_req = 1'b1;
        wait (sync_n == 1'b0);
        wait (sync_n == 1'b1);
        oe_cycles = 0; rx_bytes = 0; under_cnt = 0;
    endtask

    task automatic run_frame_counts(logic [1:0] mode, int used, string tag);
        do_sync(mode);
        repeat (512) @(negedge clk);
        #1;
        chk({tag, " enabled cycles per frame"}, 8'(oe_cycles / 16), 8'(used));
        chk({"R7 bytes received per frame ", tag}, 8'(rx_bytes), 8'(used));
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        #0.5;
        chk("R11 tx_oe in reset", {7'd0, tx_oe}, 8'd0);
        chk("R11 rx_valid in reset", {7'd0, rx_valid}, 8'd0);
        chk("R11 underrun in reset", {7'd0, underrun}, 8'd0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // R1: after sync in grouped map, slot 0 is live immediately
        do_sync(2'd0);
        @(negedge clk); #0.5;
        chk("R1 slot0 live after sync (grouped)", {7'd0, tx_oe}, 8'd1);
        repeat (600) @(negedge clk);

        // R1 with E1: slot 0 idle, slot 1 live at cycle 16
        do_sync(2'd3);
        @(negedge clk); #0.5;
        chk("R1 slot0 idle after sync (E1)", {7'd0, tx_oe}, 8'd0);
        repeat (16) @(negedge clk); #0.5;
        chk("R1 slot1 live after 16 cycles (E1)", {7'd0, tx_oe}, 8'd1);

        // whole-frame counts per map
        run_frame_counts(2'd0, 24, "R2");
        run_frame_counts(2'd1, 24, "R3");
        run_frame_counts(2'd2, 23, "R4");
        run_frame_counts(2'd3, 30, "R5");

        // R8: source stalled for a full E1 frame
        src_en = 1'b0;
        do_sync(2'd3);
        repeat (512) @(negedge clk); #1;
        chk("R8 underruns per stalled frame", 8'(under_cnt), 8'd30);
        src_en = 1'b1;

        // R10: mode request mid-frame in grouped map is deferred
        do_sync(2'd0);
        repeat (26 * 16 + 4) @(negedge clk);
        mode_req = 2'd3;
        repeat (20) @(negedge clk); #0.5;
        chk("R10 slot 27 stays idle until frame wrap", {7'd0, tx_oe}, 8'd0);
        repeat (700) @(negedge clk);

        // mid-frame resync, with an intermittent source
        repeat (37) @(negedge clk);
        do_sync(2'd1);
        for (int i = 0; i < 40; i++) begin
            repeat (23) @(negedge clk);
            src_en = ~src_en;
        end
        src_en = 1'b1;
        repeat (300) @(negedge clk);
        do_sync(2'd2);
        repeat (1100) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule